// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This block sequences the erase of a byte-wide flash array split into seven blocks of unequal size, with a small boot block at one end of the address space. Software-side command decoding supplies block-select pulses that each carry an array address. The sequencer turns every address into a block index and adds that block to an erase list. The list stays open for a settle window that starts again on every new select. When the window closes, the list is frozen and each block in it is erased in turn through a request/acknowledge handshake with the array.

Protected blocks are removed from the list without any error. The erase can be paused while the list is still open or while a block is being erased, and it can be resumed any number of times. An abort ends the operation after a recovery period. Failed blocks are recorded in sticky flags. A read-routing output shows, for a given read address, whether the array contents or the status should be returned. Every time window is measured in pulses of a tick input and set by a parameter.

Top module: `erase_seq`

## Requirements
- R1: With TOP_BOOT=1, address bits [17:13] map to blocks as follows: the three 64K regions below 30000h are blocks 0-2, 30000h-37FFFh is block 3, 38000h-39FFFh is block 4, 3A000h-3BFFFh is block 5 and 3C000h-3FFFFh is block 6. With TOP_BOOT=0 the map is mirrored: 00000h-03FFFh is block 0, 04000h is block 1, 06000h is block 2, 08000h is block 3, 10000h is block 4, 20000h is block 5 and 30000h is block 6. Bit i of pend_o and fail_map_o stands for block i.
- R2: After a select, erase_req_o rises in the cycle after the SETTLE_TICKS-th tick that follows the most recent select. Any new select starts this count again.
- R3: Once the list is frozen (started_o high), selects never add bits to pend_o.
- R4: Blocks are erased one at a time in ascending index order, with erase_blk_o naming a pending block. erase_req_o drops for at least one cycle after each acknowledge.
- R5: At the moment the list is frozen, protected blocks are dropped from pend_o. They are never requested and raise no error.
- R6: If every listed block is protected, busy_o stays high and started_o rises, but no request is issued. done_o pulses EMPTY_TICKS ticks later, with err_o unchanged.
- R7: A suspend while the list is open sets suspended_o in the next cycle. Selects are then ignored, and a resume freezes the list and raises erase_req_o in the next cycle.
- R8: A suspend during erase drops erase_req_o in the next cycle, and suspended_o rises after SUSP_TICKS ticks. On resume, the interrupted block is requested again from the start. Suspend and resume may repeat.
- R9: rd_array_o is 1 when idle. While suspended, it is 1 only for addresses outside the pending blocks. It is 0 in every other busy state.
- R10: An acknowledge with erase_fail_i sets that block's fail_map_o bit and err_o. Both stay set until clr_err_i is applied while busy_o is low.
- R11: An abort during a busy state other than the empty run drops erase_req_o and clears pend_o in the next cycle. busy_o stays high for ABORT_TICKS ticks, and no done_o pulse follows.
- R12: done_o is a one-cycle pulse at completion, with busy_o low and pend_o empty.
- R13: After reset, the block is idle with all flags and outputs low except rd_array_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base pulse that advances every window |
| sel_i | input | 1 | Block-select pulse |
| sel_addr_i | input | AW | Array address carried by the select |
| susp_i | input | 1 | Suspend request |
| resume_i | input | 1 | Resume request |
| abort_i | input | 1 | Abort request |
| clr_err_i | input | 1 | Clear fail flags and error (acts only when idle) |
| prot_i | input | 7 | Per-block protect flags |
| rd_addr_i | input | AW | Read address for routing query |
| erase_ack_i | input | 1 | Array finished the requested block |
| erase_fail_i | input | 1 | Qualifies the acknowledge as failed |
| erase_req_o | output | 1 | Erase request to the array |
| erase_blk_o | output | 3 | Block being requested |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| started_o | output | 1 | List frozen, erase phase running |
| suspended_o | output | 1 | Operation paused |
| err_o | output | 1 | Sticky error |
| fail_map_o | output | 7 | Sticky per-block failure flags |
| pend_o | output | 7 | Blocks still to be erased |
| rd_array_o | output | 1 | Read at rd_addr_i returns array data |

## Verification
The bench sets the settle window to 4 ticks, suspend to 3, abort to 2 and the empty run to 3. The tick pulses on every second clock, so each window lasts only a handful of cycles and a tick counter in the bench can check the settle count exactly. A second instance built with TOP_BOOT=0 places the mirrored address map within reach of the checks. A behavioural array with an adjustable latency makes it possible to suspend and abort in the middle of a block and to inject failures on chosen blocks.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam int NBLK  = 7;
  localparam int BLK_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_HOLD,
    ST_ERASE,
    ST_STEP,
    ST_SUSPW,
    ST_SUSP,
    ST_EMPTY,
    ST_ABORT
  } seq_state_e;

  // Block index for the top-boot layout from the five upper address bits.
  function automatic logic [BLK_W-1:0] top_layout_blk(input logic [4:0] t);
    if (t[4:3] != 2'b11)  return {1'b0, t[4:3]};
    else if (!t[2])       return 3'd3;
    else if (!t[1])       return t[0] ? 3'd5 : 3'd4;
    else                  return 3'd6;
  endfunction

endpackage

// File: rtl/ers_addr_map.sv
module ers_addr_map
  import erase_seq_pkg::*;
#(
  parameter int AW       = 18,
  parameter int TOP_BOOT = 1
) (
  input  logic [AW-1:0]    addr,
  output logic [BLK_W-1:0] blk
);

  logic [4:0] upper;
  assign upper = addr[AW-1 -: 5];

  generate
    if (TOP_BOOT != 0) begin : g_top
      assign blk = top_layout_blk(upper);
    end else begin : g_bottom
      // mirrored layout: invert address, invert index
      assign blk = BLK_W'(NBLK - 1) - top_layout_blk(~upper);
    end
  endgenerate

endmodule

// File: rtl/ers_pick.sv
module ers_pick
  import erase_seq_pkg::*;
(
  input  logic [NBLK-1:0]  mask,
  output logic [BLK_W-1:0] idx,
  output logic [NBLK-1:0]  hot
);

  always_comb begin
    idx = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (mask[i]) idx = BLK_W'(i);
    end
    hot = NBLK'(1) << idx;
  end

endmodule

// File: rtl/ers_timer.sv
module ers_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  // expire on the limit-th tick after the last clear
  assign expire = tick && (({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit});

  always_comb begin
    cnt_en = clr | (tick & ~(&cnt_q));
    cnt_n  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int AW           = 18,
  parameter int TOP_BOOT     = 1,
  parameter int SETTLE_TICKS = 2500,
  parameter int SUSP_TICKS   = 750,
  parameter int ABORT_TICKS  = 500,
  parameter int EMPTY_TICKS  = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sel_i,
  input  logic [AW-1:0]    sel_addr_i,
  input  logic             susp_i,
  input  logic             resume_i,
  input  logic             abort_i,
  input  logic             clr_err_i,
  input  logic [NBLK-1:0]  prot_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             erase_ack_i,
  input  logic             erase_fail_i,
  output logic             erase_req_o,
  output logic [BLK_W-1:0] erase_blk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             started_o,
  output logic             suspended_o,
  output logic             err_o,
  output logic [NBLK-1:0]  fail_map_o,
  output logic [NBLK-1:0]  pend_o,
  output logic             rd_array_o
);

  localparam int MAX_A = (SETTLE_TICKS > SUSP_TICKS) ? SETTLE_TICKS : SUSP_TICKS;
  localparam int MAX_B = (ABORT_TICKS > EMPTY_TICKS) ? ABORT_TICKS : EMPTY_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_T + 1);

  seq_state_e      state_q, state_n;
  logic [NBLK-1:0] pend_q, pend_n;
  logic [NBLK-1:0] fail_q, fail_n;
  logic            err_q, err_n;
  logic            done_q, done_n;

  logic [BLK_W-1:0] sel_blk, rd_blk, cur_blk;
  logic [NBLK-1:0]  sel_hot, cur_hot, eff_list;
  logic             restart, tmr_clr, tmr_exp;
  logic [TW-1:0]    tmr_limit;
  logic             abortable;

  ers_addr_map #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_sel_map (
    .addr (sel_addr_i),
    .blk  (sel_blk)
  );

  ers_addr_map #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_rd_map (
    .addr (rd_addr_i),
    .blk  (rd_blk)
  );

  ers_pick u_pick (
    .mask (pend_q),
    .idx  (cur_blk),
    .hot  (cur_hot)
  );

  ers_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .tick   (tick_i),
    .limit  (tmr_limit),
    .expire (tmr_exp)
  );

  assign sel_hot  = NBLK'(1) << sel_blk;
  assign eff_list = pend_q & ~prot_i;

  always_comb begin
    case (state_q)
      ST_SUSPW: tmr_limit = TW'(SUSP_TICKS);
      ST_EMPTY: tmr_limit = TW'(EMPTY_TICKS);
      ST_ABORT: tmr_limit = TW'(ABORT_TICKS);
      default:  tmr_limit = TW'(SETTLE_TICKS);
    endcase
  end

  assign abortable = state_q inside {ST_COLLECT, ST_HOLD, ST_ERASE,
                                     ST_STEP, ST_SUSPW, ST_SUSP};

  // next-state process
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    fail_n  = fail_q;
    err_n   = err_q;
    done_n  = 1'b0;
    restart = 1'b0;
    if (abort_i && abortable) begin
      state_n = ST_ABORT;
      pend_n  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (clr_err_i) begin
            fail_n = '0;
            err_n  = 1'b0;
          end
          if (sel_i) begin
            pend_n  = sel_hot;
            state_n = ST_COLLECT;
          end
        end
        ST_COLLECT, ST_HOLD: begin
          if (state_q == ST_COLLECT && susp_i) begin
            state_n = ST_HOLD;
          end else if (state_q == ST_COLLECT && sel_i) begin
            pend_n  = pend_q | sel_hot;
            restart = 1'b1;
          end else if ((state_q == ST_COLLECT && tmr_exp) ||
                       (state_q == ST_HOLD && resume_i)) begin
            // freeze the list, dropping protected blocks
            if (eff_list == '0) begin
              state_n = ST_EMPTY;
              pend_n  = '0;
            end else begin
              state_n = ST_ERASE;
              pend_n  = eff_list;
            end
          end
        end
        ST_ERASE: begin
          if (erase_ack_i) begin
            pend_n  = pend_q & ~cur_hot;
            state_n = ST_STEP;
            if (erase_fail_i) begin
              fail_n = fail_q | cur_hot;
              err_n  = 1'b1;
            end
          end else if (susp_i) begin
            state_n = ST_SUSPW;
          end
        end
        ST_STEP: begin
          if (pend_q == '0) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else if (susp_i) begin
            state_n = ST_SUSPW;
          end else begin
            state_n = ST_ERASE;
          end
        end
        ST_SUSPW: if (tmr_exp) state_n = ST_SUSP;
        ST_SUSP:  if (resume_i) state_n = ST_ERASE;
        ST_EMPTY: begin
          if (tmr_exp) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end
        end
        ST_ABORT: if (tmr_exp) state_n = ST_IDLE;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  assign tmr_clr = restart || (state_n != state_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      fail_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      fail_q  <= fail_n;
      err_q   <= err_n;
      done_q  <= done_n;
    end
  end

  // outputs
  assign erase_req_o = (state_q == ST_ERASE);
  assign erase_blk_o = cur_blk;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign started_o   = state_q inside {ST_ERASE, ST_STEP, ST_SUSPW, ST_SUSP, ST_EMPTY};
  assign suspended_o = state_q inside {ST_HOLD, ST_SUSP};
  assign err_o       = err_q;
  assign fail_map_o  = fail_q;
  assign pend_o      = pend_q;

  always_comb begin
    case (state_q)
      ST_IDLE:         rd_array_o = 1'b1;
      ST_HOLD, ST_SUSP: rd_array_o = ~pend_q[rd_blk];
      default:         rd_array_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ers_seq_chk.sv
module ers_seq_chk
  import erase_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             susp_i,
  input logic             abort_i,
  input logic             clr_err_i,
  input logic             erase_ack_i,
  input logic             erase_req_o,
  input logic [BLK_W-1:0] erase_blk_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             started_o,
  input logic             suspended_o,
  input logic             err_o,
  input logic [NBLK-1:0]  pend_o
);

  // R4
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req_o && erase_ack_i && !abort_i) |=> !erase_req_o);

  // R4
  req_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |-> pend_o[erase_blk_o]);

  // R8
  susp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req_o && susp_i && !erase_ack_i && !abort_i) |=> (!erase_req_o && !suspended_o));

  // R3
  no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started_o |=> ((pend_o & ~$past(pend_o)) == '0));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(clr_err_i && !busy_o)) |=> err_o);

  // R12
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && pend_o == '0));

  // R11
  abort_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && erase_req_o) |=> (busy_o && !erase_req_o && pend_o == '0));

endmodule

bind erase_seq ers_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .susp_i      (susp_i),
  .abort_i     (abort_i),
  .clr_err_i   (clr_err_i),
  .erase_ack_i (erase_ack_i),
  .erase_req_o (erase_req_o),
  .erase_blk_o (erase_blk_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .started_o   (started_o),
  .suspended_o (suspended_o),
  .err_o       (err_o),
  .pend_o      (pend_o)
);

// File: tb/erase_seq_test.sv
`timescale 1ns/1ps
module erase_seq_test;

  localparam int SETTLE = 4;
  localparam int SUSPT  = 3;
  localparam int ABORTT = 2;
  localparam int EMPTYT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sel = 1'b0, sel_b = 1'b0;
  logic [17:0] sel_addr = '0;
  logic susp = 1'b0, resume = 1'b0, abort = 1'b0, clr_err = 1'b0;
  logic [6:0] prot = '0;
  logic [17:0] rd_addr = '0;
  logic ack = 1'b0, fail = 1'b0;

  logic req, busy, done, started, suspended, err, rd_arr;
  logic [2:0] blk;
  logic [6:0] fail_map, pend;

  logic req_b, busy_b, done_b, started_b, susp_b, err_b, rd_arr_b;
  logic [2:0] blk_b;
  logic [6:0] fail_map_b, pend_b;

  int nchk = 0, nerr = 0;
  int tcount = 0, ndone = 0, nlog = 0, acnt = 0;
  int alat = 5;
  logic [6:0] fail_mask = '0;
  int elog [64];

  always #10 clk = ~clk;

  always @(posedge clk) tick <= ~tick;

  always @(posedge clk) begin
    if (sel) tcount <= 0;
    else if (tick) tcount <= tcount + 1;
    if (done) ndone <= ndone + 1;
  end

  // behavioural array
  always @(posedge clk) begin
    ack  <= 1'b0;
    fail <= 1'b0;
    if (!req || ack) acnt <= 0;
    else if (acnt >= alat) begin
      ack  <= 1'b1;
      fail <= fail_mask[blk];
      elog[nlog % 64] <= int'(blk);
      nlog <= nlog + 1;
      acnt <= 0;
    end else acnt <= acnt + 1;
  end

  erase_seq #(.AW(18), .TOP_BOOT(1), .SETTLE_TICKS(SETTLE), .SUSP_TICKS(SUSPT),
              .ABORT_TICKS(ABORTT), .EMPTY_TICKS(EMPTYT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sel_i(sel), .sel_addr_i(sel_addr),
    .susp_i(susp), .resume_i(resume), .abort_i(abort), .clr_err_i(clr_err),
    .prot_i(prot), .rd_addr_i(rd_addr), .erase_ack_i(ack), .erase_fail_i(fail),
    .erase_req_o(req), .erase_blk_o(blk), .busy_o(busy), .done_o(done),
    .started_o(started), .suspended_o(suspended), .err_o(err),
    .fail_map_o(fail_map), .pend_o(pend), .rd_array_o(rd_arr));

  erase_seq #(.AW(18), .TOP_BOOT(0), .SETTLE_TICKS(SETTLE), .SUSP_TICKS(SUSPT),
              .ABORT_TICKS(ABORTT), .EMPTY_TICKS(EMPTYT)) uut_bot (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sel_i(sel_b), .sel_addr_i(sel_addr),
    .susp_i(1'b0), .resume_i(1'b0), .abort_i(abort), .clr_err_i(1'b0),
    .prot_i(7'd0), .rd_addr_i(rd_addr), .erase_ack_i(1'b0), .erase_fail_i(1'b0),
    .erase_req_o(req_b), .erase_blk_o(blk_b), .busy_o(busy_b), .done_o(done_b),
    .started_o(started_b), .suspended_o(susp_b), .err_o(err_b),
    .fail_map_o(fail_map_b), .pend_o(pend_b), .rd_array_o(rd_arr_b));

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic pulse_sel(input logic [17:0] a);
    sel = 1'b1; sel_addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic pulse_susp();
    susp = 1'b1; @(negedge clk); susp = 1'b0;
  endtask

  task automatic pulse_resume();
    resume = 1'b1; @(negedge clk); resume = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!req && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic wait_done(output bit seen);
    int n;
    n = 0; seen = 1'b0;
    while (!seen && n < 3000) begin
      @(negedge clk); n++;
      if (done) seen = 1'b1;
    end
  endtask

  task automatic t_reset();
    chk("R13", "busy after reset", busy, 0);
    chk("R13", "req after reset", req, 0);
    chk("R13", "pend after reset", pend, 0);
    chk("R13", "err/fail after reset", {err, fail_map}, 0);
    chk("R9", "rd_array idle", rd_arr, 1);
  endtask

  task automatic t_window();
    int n, base;
    bit seen;
    alat = 10; base = nlog;
    pulse_sel(18'h3BFFF);
    repeat (3) @(negedge clk);
    chk("R2", "req before window end", req, 0);
    chk("R1", "pend after 3BFFF select", pend, 7'b0100000);
    pulse_sel(18'h37FFF);
    wait_req(n);
    chk("R2", "ticks from last select to req", tcount, SETTLE);
    chk("R4", "first block is lowest", blk, 3);
    chk("R3", "started after freeze", started, 1);
    pulse_sel(18'h00000);
    chk("R3", "select ignored after start", pend, 7'b0101000);
    wait_done(seen);
    chk("R12", "done pulse seen", seen, 1);
    chk("R12", "busy at done", busy, 0);
    chk("R12", "pend at done", pend, 0);
    chk("R4", "blocks erased", nlog - base, 2);
    chk("R4", "first erased block", elog[base % 64], 3);
    chk("R4", "second erased block", elog[(base + 1) % 64], 5);
    @(negedge clk);
    chk("R12", "done lasts one cycle", done, 0);
  endtask

  task automatic t_protect();
    int n, base;
    bit seen;
    alat = 5; base = nlog; prot = 7'b0000010;
    pulse_sel(18'h1FFFF);
    pulse_sel(18'h20000);
    wait_req(n);
    chk("R5", "protected block dropped", pend, 7'b0000100);
    wait_done(seen);
    chk("R5", "err after skip", err, 0);
    chk("R5", "only unprotected erased", nlog - base, 1);
    chk("R5", "erased block index", elog[base % 64], 2);
    prot = '0;
  endtask

  task automatic t_allprot();
    int n, base, after;
    bit sawreq, sawstart, seen;
    base = nlog; prot = 7'b1000000;
    sawreq = 0; sawstart = 0; seen = 0; n = 0; after = 0;
    pulse_sel(18'h3C000);
    while (!seen && n < 500) begin
      @(negedge clk); n++;
      if (req) sawreq = 1;
      if (sawstart) after++;
      if (started && !sawstart) begin
        sawstart = 1;
        chk("R6", "pend empty in dummy run", pend, 0);
        chk("R6", "busy in dummy run", busy, 1);
      end
      if (done) seen = 1;
    end
    chk("R6", "dummy run started", sawstart, 1);
    chk("R6", "no request issued", sawreq, 0);
    chk("R6", "done seen", seen, 1);
    chk("R6", "dummy run long enough", after >= EMPTYT, 1);
    chk("R6", "no error", err, 0);
    chk("R6", "nothing erased", nlog - base, 0);
    prot = '0;
  endtask

  task automatic t_hold();
    bit seen;
    alat = 5;
    pulse_sel(18'h00000);
    pulse_susp();
    chk("R7", "suspended immediately", suspended, 1);
    repeat (2 * SETTLE + 6) @(negedge clk);
    chk("R7", "no erase while held", req, 0);
    chk("R7", "still busy while held", busy, 1);
    pulse_sel(18'h38000);
    chk("R7", "select ignored while held", pend, 7'b0000001);
    rd_addr = 18'h38000; #1;
    chk("R9", "read outside list goes to array", rd_arr, 1);
    rd_addr = 18'h00010; #1;
    chk("R9", "read inside list gives status", rd_arr, 0);
    pulse_resume();
    chk("R7", "resume starts erase at once", req, 1);
    chk("R7", "block after resume", blk, 0);
    wait_done(seen);
    chk("R7", "done after resume", seen, 1);
  endtask

  task automatic t_suspend();
    int n, base;
    bit seen;
    alat = 30; base = nlog;
    pulse_sel(18'h00000);
    pulse_sel(18'h30000);
    wait_req(n);
    repeat (4) @(negedge clk);
    pulse_susp();
    chk("R8", "req drops on suspend", req, 0);
    chk("R8", "not yet suspended", suspended, 0);
    rd_addr = 18'h3A000; #1;
    chk("R9", "status while stopping", rd_arr, 0);
    n = 0;
    while (!suspended && n < 100) begin @(negedge clk); n++; end
    chk("R8", "suspended reached", suspended, 1);
    chk("R8", "stop delay covers window", n >= SUSPT, 1);
    chk("R9", "other block reads array", rd_arr, 1);
    rd_addr = 18'h30000; #1;
    chk("R9", "pending block reads status", rd_arr, 0);
    pulse_resume();
    chk("R8", "req after resume", req, 1);
    chk("R8", "same block after resume", blk, 0);
    repeat (3) @(negedge clk);
    pulse_susp();
    n = 0;
    while (!suspended && n < 100) begin @(negedge clk); n++; end
    chk("R8", "second suspend", suspended, 1);
    pulse_resume();
    wait_done(seen);
    chk("R8", "done after repeated suspend", seen, 1);
    chk("R8", "each block acknowledged once", nlog - base, 2);
    chk("R8", "order after suspend", elog[base % 64] * 10 + elog[(base + 1) % 64], 3);
  endtask

  task automatic t_fail();
    bit seen;
    alat = 5; fail_mask = 7'b0000100;
    pulse_sel(18'h20000);
    pulse_sel(18'h38000);
    wait_done(seen);
    chk("R10", "err after failure", err, 1);
    chk("R10", "fail map", fail_map, 7'b0000100);
    fail_mask = '0;
    pulse_sel(18'h10000);
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
    chk("R10", "clear ignored while busy", err, 1);
    wait_done(seen);
    chk("R10", "err sticky over good run", err, 1);
    chk("R10", "fail map sticky", fail_map, 7'b0000100);
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
    chk("R10", "err cleared when idle", err, 0);
    chk("R10", "fail map cleared", fail_map, 0);
  endtask

  task automatic t_abort();
    int n, base, d0;
    alat = 40; base = nlog;
    pulse_sel(18'h10000);
    wait_req(n);
    repeat (3) @(negedge clk);
    d0 = ndone;
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk("R11", "req dropped on abort", req, 0);
    chk("R11", "pend cleared on abort", pend, 0);
    chk("R11", "busy during recovery", busy, 1);
    n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    chk("R11", "recovery ends", busy, 0);
    chk("R11", "recovery length", n >= ABORTT, 1);
    repeat (2) @(negedge clk);
    chk("R11", "no done after abort", ndone - d0, 0);
    chk("R11", "no acknowledge logged", nlog - base, 0);
  endtask

  task automatic t_bottom();
    sel_b = 1'b1; sel_addr = 18'h00000; @(negedge clk);
    chk("R1", "bottom 00000", pend_b, 7'b0000001);
    sel_addr = 18'h04000; @(negedge clk);
    chk("R1", "bottom 04000", pend_b, 7'b0000011);
    sel_addr = 18'h06000; @(negedge clk);
    chk("R1", "bottom 06000", pend_b, 7'b0000111);
    sel_addr = 18'h08000; @(negedge clk);
    chk("R1", "bottom 08000", pend_b, 7'b0001111);
    sel_addr = 18'h10000; @(negedge clk);
    chk("R1", "bottom 10000", pend_b, 7'b0011111);
    sel_addr = 18'h3FFFF; @(negedge clk);
    chk("R1", "bottom 3FFFF", pend_b, 7'b1011111);
    sel_b = 1'b0;
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11", "bottom instance recovered", busy_b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_protect();
    t_allprot();
    t_hold();
    t_suspend();
    t_fail();
    t_abort();
    t_bottom();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL all: watchdog expired, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule